// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital core of a half-bridge gate driver for a synchronous buck stage. It turns a three-level PWM command, already reduced to two qualified bits, into two gate enables: `gh_o` for the high-side switch and `gl_o` for the low-side switch. A supply-good flag and an active-low disable input gate the whole stage. An active-low skip input suppresses only the low-side gate, which gives diode-emulation operation at light load. A PWM level held in the mid window shuts the stage down, but only after a hold-off time.

Dead time is adaptive. Two digital comparator inputs are used. One reports that the low-side gate has fallen below its threshold; the other reports that the switch node has fallen below its threshold. The incoming gate is released a fixed number of cycles after its comparator reports. If the report never comes, the gate is released after a bounded wait. All inputs are synchronized by two flops.

Top module: `buck_gate_seq`

## Requirements
- R1: When `supply_ok_i` is low or `disable_ni` is low, `gh_o` and `gl_o` are both low, whatever the PWM, skip and comparator inputs are.
- R2: During reset and after it, both outputs stay low until `disable_ni` is seen high. A disable input tied low, which is how an undriven pin is pulled, keeps both outputs low.
- R3: When enabled with PWM high (`pwm_hi_i`=1, `pwm_lo_i`=0), `gh_o` is high and `gl_o` is low, whatever `skip_ni` is.
- R4: When enabled with PWM low (`pwm_hi_i`=0, `pwm_lo_i`=1), `gl_o` is high if `skip_ni` is high and low if `skip_ni` is low. `gh_o` is low in both cases.
- R5: A mid-window PWM code (both bits 0 or both bits 1) seen for fewer than HOLD_CYC consecutive cycles leaves the outputs on the previous command.
- R6: A mid-window code seen for HOLD_CYC consecutive cycles drives both outputs low, one cycle after the hold-off expires.
- R7: On leaving the mid window, the block follows the new command. If the relevant comparator already reports below threshold, the gate rises on the fourth clock edge after the PWM inputs change: two synchronizer stages, one decode stage and one gate stage.
- R8: On a PWM low-to-high change, `gl_o` falls on the fourth edge. `gh_o` rises only after `gl_below_i` is reported plus DEAD_CYC cycles, which is the (3+DEAD_CYC)-th edge after `gl_below_i` rises.
- R9: On a PWM high-to-low change, `gh_o` falls on the fourth edge. `gl_o` rises only after `sw_below_i` is reported plus DEAD_CYC cycles, which is the (3+DEAD_CYC)-th edge after `sw_below_i` rises.
- R10: If the awaited comparator never reports, the pending gate rises after MAX_WAIT waiting cycles plus DEAD_CYC cycles. For a low-to-high change this is edge 4+MAX_WAIT+DEAD_CYC after the PWM change.
- R11: `gh_o` and `gl_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | Qualified PWM bit: above the upper threshold |
| pwm_lo_i | input | 1 | Qualified PWM bit: below the lower threshold |
| supply_ok_i | input | 1 | Bias supply good, hysteresis applied upstream |
| disable_ni | input | 1 | Output disable, active low |
| skip_ni | input | 1 | Skip mode, active low; low keeps the low side off |
| gl_below_i | input | 1 | Low-side gate below its turn-off threshold |
| sw_below_i | input | 1 | Switch node below its threshold |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |

## Verification
The hold-off expiry and the return of a valid PWM level can fall on neighbouring cycles. At that point a shutdown and a restart compete for the gate stage. The bench provokes this by holding the mid code for exactly HOLD_CYC samples and restoring PWM high on the next sample. It expects `gh_o` to drop for exactly one cycle and then rise on the following edge; holding the mid code one sample less must leave `gh_o` high throughout. A comparator report and a wait timeout can also land close together. The bench separates the two by reporting early in one run and withholding the report in another, and checks the exact edge on which the gate rises in each.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;
  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_LOW  = 2'd1,
    CMD_HIGH = 2'd2,
    CMD_MID  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HS,
    ST_LS,
    ST_WAIT_GL,
    ST_DEAD_HS,
    ST_WAIT_SW,
    ST_DEAD_LS
  } gate_st_e;
endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bgs_cmd_holdoff.sv
module bgs_cmd_holdoff
  import buck_gate_pkg::*;
#(
  parameter int HOLD_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  output cmd_e cmd_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  cmd_e          raw;
  cmd_e          cmd_q;
  logic [CW-1:0] mid_cnt_q;

  always_comb begin
    unique case ({pwm_hi_i, pwm_lo_i})
      2'b10:   raw = CMD_HIGH;
      2'b01:   raw = CMD_LOW;
      default: raw = CMD_MID;
    endcase
  end

  // mid code holds the last valid command until the hold-off expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_OFF;
      mid_cnt_q <= '0;
    end else if (raw != CMD_MID) begin
      cmd_q     <= raw;
      mid_cnt_q <= '0;
    end else if (mid_cnt_q == HOLD_LAST) begin
      cmd_q     <= CMD_OFF;
    end else begin
      mid_cnt_q <= mid_cnt_q + 1'b1;
    end
  end

  assign cmd_o = cmd_q;

  p_off_needs_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_OFF && $past(cmd_q) != CMD_OFF) |-> $past(raw == CMD_MID));

  p_valid_exits_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw != CMD_MID) |=> (cmd_q != CMD_OFF));

  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_cnt_q <= HOLD_LAST);
endmodule

// File: rtl/bgs_gate_fsm.sv
module bgs_gate_fsm
  import buck_gate_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int MAX_WAIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic skip_ni,
  input  cmd_e cmd_i,
  input  logic gl_below_i,
  input  logic sw_below_i,
  output logic gh_o,
  output logic gl_o
);
  localparam int MAXC = (DEAD_CYC > MAX_WAIT) ? DEAD_CYC : MAX_WAIT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(MAX_WAIT - 1);

  gate_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          gh_q, gl_q;
  logic          want_hs, want_ls;

  assign want_hs = en_i && (cmd_i == CMD_HIGH);
  assign want_ls = en_i && (cmd_i == CMD_LOW) && skip_ni;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (want_hs)      st_d = gl_below_i ? ST_HS : ST_WAIT_GL;
          else if (want_ls) st_d = sw_below_i ? ST_LS : ST_WAIT_SW;
        end
        ST_HS: if (!want_hs) begin
          st_d  = want_ls ? ST_WAIT_SW : ST_IDLE;
          cnt_d = '0;
        end
        ST_LS: if (!want_ls) begin
          st_d  = want_hs ? ST_WAIT_GL : ST_IDLE;
          cnt_d = '0;
        end
        ST_WAIT_GL: begin
          if (!want_hs) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (gl_below_i || cnt_q == WAIT_LAST) begin
            st_d  = ST_DEAD_HS;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_DEAD_HS: begin
          if (!want_hs) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (cnt_q == DEAD_LAST) begin
            st_d  = ST_HS;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_WAIT_SW: begin
          if (!want_ls) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (sw_below_i || cnt_q == WAIT_LAST) begin
            st_d  = ST_DEAD_LS;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_DEAD_LS: begin
          if (!want_ls) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (cnt_q == DEAD_LAST) begin
            st_d  = ST_LS;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      gh_q  <= 1'b0;
      gl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      gh_q  <= (st_d == ST_HS);
      gl_q  <= (st_d == ST_LS);
    end
  end

  assign gh_o = gh_q;
  assign gl_o = gl_q;

  p_disable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gh_q && !gl_q));

  p_skip_blocks_gl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_ni |=> !gl_q);

  p_gh_after_gl_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gh_q) |-> !$past(gl_q));

  p_gl_after_gh_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gl_q) |-> !$past(gh_q));

  p_wait_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_GL || st_q == ST_WAIT_SW) |-> (cnt_q <= WAIT_LAST));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int HOLD_CYC = 18,
  parameter int DEAD_CYC = 2,
  parameter int MAX_WAIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic supply_ok_i,
  input  logic disable_ni,
  input  logic skip_ni,
  input  logic gl_below_i,
  input  logic sw_below_i,
  output logic gh_o,
  output logic gl_o
);
  localparam int NSYNC = 7;

  logic [NSYNC-1:0] raw_in, sync_in;
  logic pwm_hi_s, pwm_lo_s, supply_s, dis_n_s, skip_n_s, gl_below_s, sw_below_s;
  logic en_s;
  cmd_e cmd;

  assign raw_in = {pwm_hi_i, pwm_lo_i, supply_ok_i, disable_ni, skip_ni, gl_below_i, sw_below_i};

  bgs_sync #(.W(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign {pwm_hi_s, pwm_lo_s, supply_s, dis_n_s, skip_n_s, gl_below_s, sw_below_s} = sync_in;
  assign en_s = supply_s && dis_n_s;

  bgs_cmd_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_hi_i(pwm_hi_s),
    .pwm_lo_i(pwm_lo_s),
    .cmd_o   (cmd)
  );

  bgs_gate_fsm #(.DEAD_CYC(DEAD_CYC), .MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_s),
    .skip_ni   (skip_n_s),
    .cmd_i     (cmd),
    .gl_below_i(gl_below_s),
    .sw_below_i(sw_below_s),
    .gh_o      (gh_o),
    .gl_o      (gl_o)
  );

  p_no_overlap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gh_o && gl_o));

  p_gate_off_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dis_n_s && $past(!dis_n_s)) |-> (!gh_o && !gl_o));
endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
  localparam int HOLD = 8;
  localparam int DEAD = 3;
  localparam int MWAIT = 10;
  localparam int NVEC = 11;
  // {hi, lo, supply, dis_n, skip_n, gl_below, sw_below, exp_gh, exp_gl}
  localparam logic [8:0] VECS [NVEC] = '{
    9'b1_0_1_1_1_1_1_1_0,
    9'b0_1_1_1_1_1_1_0_1,
    9'b0_1_1_1_0_1_1_0_0,
    9'b1_0_1_1_0_1_1_1_0,
    9'b1_0_1_0_1_1_1_0_0,
    9'b0_1_0_1_1_1_1_0_0,
    9'b0_1_1_1_1_1_1_0_1,
    9'b0_0_1_1_1_1_1_0_0,
    9'b1_0_1_1_1_1_1_1_0,
    9'b1_1_1_1_1_1_1_0_0,
    9'b1_0_1_1_1_1_1_1_0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_hi, pwm_lo, sup, dis_n, skip_n, glb, swb;
  logic gh, gl;
  int   n_chk = 0;
  int   n_bad = 0;
  int   n_ovl = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  buck_gate_seq #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD), .MAX_WAIT(MWAIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
    .supply_ok_i(sup), .disable_ni(dis_n), .skip_ni(skip_n),
    .gl_below_i(glb), .sw_below_i(swb), .gh_o(gh), .gl_o(gl)
  );

  always @(negedge clk) if (rst_n && gh && gl) n_ovl++;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0, 3, 8, 10: return "R3 pwm high";
      1, 2, 6:     return "R4 pwm low / skip";
      4, 5:        return "R1 disable / supply";
      default:     return "R6 mid long";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {pwm_hi, pwm_lo, sup, dis_n, skip_n, glb, swb} = '0;
    tick(3);
    chk("R2 reset gh", gh, 1'b0);
    chk("R2 reset gl", gl, 1'b0);
    rst_n = 1'b1;
    {pwm_hi, pwm_lo, sup, dis_n, skip_n, glb, swb} = 7'b1_0_1_0_1_1_1;
    tick(12);
    chk("R2 tied-low disable gh", gh, 1'b0);
    chk("R2 tied-low disable gl", gl, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {pwm_hi, pwm_lo, sup, dis_n, skip_n, glb, swb} = VECS[i][8:2];
      tick(20);
      chk({vec_tag(i), " gh"}, gh, VECS[i][1]);
      chk({vec_tag(i), " gl"}, gl, VECS[i][0]);
    end

    // R5: mid for HOLD-1 samples keeps GH
    begin
      logic kept;
      kept = 1'b1;
      {pwm_hi, pwm_lo} = 2'b00;
      for (int k = 0; k < HOLD - 1; k++) begin
        tick(1);
        if (!gh) kept = 1'b0;
      end
      {pwm_hi, pwm_lo} = 2'b10;
      for (int k = 0; k < 8; k++) begin
        tick(1);
        if (!gh || gl) kept = 1'b0;
      end
      chk("R5 short mid keeps gh", kept, 1'b1);
    end

    // R6/R7 boundary: mid exactly HOLD samples, then high
    {pwm_hi, pwm_lo} = 2'b00;
    tick(HOLD);
    {pwm_hi, pwm_lo} = 2'b10;
    tick(2);
    chk("R6 before expiry gh", gh, 1'b1);
    tick(1);
    chk("R6 expiry drops gh", gh, 1'b0);
    tick(1);
    chk("R7 immediate re-entry gh", gh, 1'b1);

    // R7 exit to low after shutdown
    {pwm_hi, pwm_lo} = 2'b00;
    tick(20);
    chk("R6 long mid gh", gh, 1'b0);
    {pwm_hi, pwm_lo} = 2'b01;
    tick(3);
    chk("R7 low exit edge3 gl", gl, 1'b0);
    tick(1);
    chk("R7 low exit edge4 gl", gl, 1'b1);

    // R8: low to high with late gate comparator
    glb = 1'b0;
    tick(20);
    {pwm_hi, pwm_lo} = 2'b10;
    tick(3);
    chk("R8 gl still on edge3", gl, 1'b1);
    tick(1);
    chk("R8 gl off edge4", gl, 1'b0);
    tick(2);
    chk("R8 gh waits for comparator", gh, 1'b0);
    glb = 1'b1;
    tick(5);
    chk("R8 gh before dead end", gh, 1'b0);
    tick(1);
    chk("R8 gh after dead time", gh, 1'b1);

    // R10: comparator never reports
    {pwm_hi, pwm_lo} = 2'b01;
    tick(20);
    glb = 1'b0;
    tick(5);
    chk("R4 gl on before R10 test", gl, 1'b1);
    {pwm_hi, pwm_lo} = 2'b10;
    tick(4 + MWAIT + DEAD - 1);
    chk("R10 gh before timeout", gh, 1'b0);
    tick(1);
    chk("R10 gh after timeout", gh, 1'b1);

    // R9: high to low with late switch-node comparator
    glb = 1'b1;
    swb = 1'b0;
    tick(20);
    {pwm_hi, pwm_lo} = 2'b01;
    tick(3);
    chk("R9 gh still on edge3", gh, 1'b1);
    tick(1);
    chk("R9 gh off edge4", gh, 1'b0);
    tick(2);
    chk("R9 gl waits for comparator", gl, 1'b0);
    swb = 1'b1;
    tick(5);
    chk("R9 gl before dead end", gl, 1'b0);
    tick(1);
    chk("R9 gl after dead time", gl, 1'b1);

    tick(2);
    chk("R11 no overlap cycles", (n_ovl == 0), 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule